// File: doc/BRIEF.md
# Split-Strobe to Data-Strobe Bus Bridge

This block sits between a host bus that signals reads and writes on two separate active-low strobes and a peripheral bus that expects one active-low data strobe, a read/write level and an active-low acknowledge. It builds the peripheral data strobe from the two host strobes. On reads the data strobe follows the read strobe at once. On writes it is held back to the next falling edge of the host clock, so write data has settled before the strobe's leading edge.

The peripheral read/write level is the inverse of the host direction signal. The host chip select and the low address bits pass straight through to the peripheral. The acknowledge arrives asynchronously, so it goes through a synchroniser. Until the synchronised acknowledge is seen, the block holds host ready low, which inserts wait states into the host cycle. When chip select is inactive, ready stays high and the data strobe stays released.

Top module: `strobe_bridge`

## Requirements
- R1: With chip select active, a low host read strobe drives the data strobe low in the same instant, with no clock edge in between.
- R2: With chip select active, a low host write strobe leaves the data strobe high until the first falling clock edge that samples the write strobe low. After that edge the data strobe goes low.
- R3: The data strobe returns high as soon as the host strobe that started the cycle returns high, without waiting for a clock edge.
- R4: The peripheral read/write output is the inverse of the host direction input: direction 1 (host transmits) gives 0 (peripheral write), and direction 0 gives 1.
- R5: The peripheral chip select equals the host chip select, and the peripheral register-select bits equal the host address bits, with no delay.
- R6: While chip select is active, host ready is low until the acknowledge has been sampled low on a rising edge and has passed through the second synchroniser stage. If the acknowledge is first driven low after the L-th rising edge following the strobe, ready is first seen high after rising edge L+2.
- R7: While chip select is inactive, host ready is high and the data strobe is high, whatever the host strobes are doing.
- R8: While reset is high, the synchroniser and the write delay register are held clear. An acknowledge that is low during reset therefore does not raise ready for an active chip select.
- R9: For as long as ready is low during an active cycle, the data strobe stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst | input | 1 | Synchronous reset, active high |
| host_sel_n | input | 1 | Decoded peripheral chip select from the host, active low |
| host_rd_n | input | 1 | Host read strobe, active low |
| host_wr_n | input | 1 | Host write strobe, active low |
| host_dir | input | 1 | Host data direction, 1 = host transmits |
| host_addr | input | ADDR_W | Low host address bits |
| host_rdy | output | 1 | Ready to the host, low inserts wait states |
| per_sel_n | output | 1 | Peripheral chip select, active low |
| per_ds_n | output | 1 | Peripheral data strobe, active low |
| per_rw | output | 1 | Peripheral read/write, 1 = read |
| per_rs | output | ADDR_W | Peripheral register select |
| per_ack_n | input | 1 | Peripheral data acknowledge, asynchronous, active low |

## Verification
The host signals are driven one time unit after a rising edge. The read strobe, read/write, select and register-select results are combinational, so they are compared one time unit later, in the same cycle. The delayed write strobe is compared twice: just after the strobe is driven, when it must still be high, and just after the following falling edge, when it must be low. A peripheral model drives the acknowledge low after a programmed number L of rising edges. The bench counts rising edges, sampling two time units after each one, until ready is seen high, and expects exactly L+2. Between cycles the bench idles long enough for the synchroniser to clear.

// File: rtl/strobe_bridge_pkg.sv
package strobe_bridge_pkg;

  typedef enum logic [1:0] {
    XFER_NONE  = 2'd0,
    XFER_READ  = 2'd1,
    XFER_WRITE = 2'd2
  } xfer_kind_e;

  localparam int unsigned MIN_SYNC_STAGES = 2;

endpackage

// File: rtl/wr_half_delay.sv
// Captures the host write strobe on the falling clock edge, giving the
// half-cycle lag that lets write data settle before the data strobe.
module wr_half_delay (
  input  logic clk,
  input  logic rst,
  input  logic wr_n,
  output logic wr_late_n
);

  always_ff @(negedge clk) begin
    if (rst) begin
      wr_late_n <= 1'b1;
    end else begin
      wr_late_n <= wr_n;
    end
  end

endmodule

// File: rtl/ack_sync.sv
// Multi-stage synchroniser for the asynchronous active-low acknowledge.
module ack_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic ack_n,
  output logic ack_seen
);

  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain[0] <= 1'b0;
    end else begin
      chain[0] <= ~ack_n;
    end
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) begin
        chain[g] <= 1'b0;
      end else begin
        chain[g] <= chain[g-1];
      end
    end
  end

  assign ack_seen = chain[STAGES-1];

endmodule

// File: rtl/strobe_gen.sv
// Forms the single data strobe from split host strobes.
module strobe_gen
  import strobe_bridge_pkg::*;
(
  input  logic sel_n,
  input  logic rd_n,
  input  logic wr_n,
  input  logic wr_late_n,
  output logic ds_n
);

  xfer_kind_e kind;

  always_comb begin
    if (sel_n) begin
      kind = XFER_NONE;
    end else if (!rd_n) begin
      kind = XFER_READ;
    end else if (!wr_n) begin
      kind = XFER_WRITE;
    end else begin
      kind = XFER_NONE;
    end
  end

  always_comb begin
    unique case (kind)
      XFER_READ:  ds_n = 1'b0;
      XFER_WRITE: ds_n = wr_late_n;
      default:    ds_n = 1'b1;
    endcase
  end

endmodule

// File: rtl/ready_gen.sv
// Holds host ready low while the peripheral is selected and unacknowledged.
module ready_gen (
  input  logic sel_n,
  input  logic ack_seen,
  output logic rdy
);

  always_comb begin
    rdy = sel_n | ack_seen;
  end

endmodule

// File: rtl/strobe_bridge.sv
module strobe_bridge
  import strobe_bridge_pkg::*;
#(
  parameter int unsigned ADDR_W      = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_sel_n,
  input  logic              host_rd_n,
  input  logic              host_wr_n,
  input  logic              host_dir,
  input  logic [ADDR_W-1:0] host_addr,
  output logic              host_rdy,
  output logic              per_sel_n,
  output logic              per_ds_n,
  output logic              per_rw,
  output logic [ADDR_W-1:0] per_rs,
  input  logic              per_ack_n
);

  localparam int unsigned STAGES_EFF =
    (SYNC_STAGES < MIN_SYNC_STAGES) ? MIN_SYNC_STAGES : SYNC_STAGES;

  logic wr_late_n;
  logic ack_seen;

  wr_half_delay u_wr_delay (
    .clk       (clk),
    .rst       (rst),
    .wr_n      (host_wr_n),
    .wr_late_n (wr_late_n)
  );

  strobe_gen u_strobe (
    .sel_n     (host_sel_n),
    .rd_n      (host_rd_n),
    .wr_n      (host_wr_n),
    .wr_late_n (wr_late_n),
    .ds_n      (per_ds_n)
  );

  ack_sync #(.STAGES(STAGES_EFF)) u_ack_sync (
    .clk      (clk),
    .rst      (rst),
    .ack_n    (per_ack_n),
    .ack_seen (ack_seen)
  );

  ready_gen u_ready (
    .sel_n    (host_sel_n),
    .ack_seen (ack_seen),
    .rdy      (host_rdy)
  );

  assign per_rw    = ~host_dir;
  assign per_sel_n = host_sel_n;
  assign per_rs    = host_addr;

endmodule

// File: rtl/strobe_bridge_chk.sv
module strobe_bridge_chk #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input logic clk,
  input logic rst,
  input logic host_sel_n,
  input logic host_rd_n,
  input logic host_wr_n,
  input logic host_rdy,
  input logic per_ds_n,
  input logic per_ack_n
);

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    host_sel_n |-> (host_rdy && per_ds_n)); // R7

  AST_RDY_DROP_SELECTED: assert property (@(posedge clk) disable iff (rst)
    $fell(host_rdy) |-> !host_sel_n); // R6

  AST_DS_HELD: assert property (@(posedge clk) disable iff (rst)
    (!per_ds_n && !host_rdy) |=> (!per_ds_n || host_sel_n || (host_rd_n && host_wr_n))); // R9

  AST_WR_LAGS: assert property (@(negedge clk) disable iff (rst)
    (!host_sel_n && host_rd_n && !host_wr_n && $past(host_wr_n)) |-> per_ds_n); // R2

  if (SYNC_STAGES == 2) begin : g_lat2
    AST_ACK_LATENCY: assert property (@(posedge clk) disable iff (rst)
      ($rose(host_rdy) && !host_sel_n) |-> $past(!per_ack_n, 2)); // R6
  end

endmodule

bind strobe_bridge strobe_bridge_chk #(.SYNC_STAGES(SYNC_STAGES)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .host_sel_n (host_sel_n),
  .host_rd_n  (host_rd_n),
  .host_wr_n  (host_wr_n),
  .host_rdy   (host_rdy),
  .per_ds_n   (per_ds_n),
  .per_ack_n  (per_ack_n)
);

// File: tb/strobe_bridge_tb.sv
`timescale 1ns/1ps
module strobe_bridge_tb;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          host_sel_n = 1'b1;
  logic          host_rd_n = 1'b1;
  logic          host_wr_n = 1'b1;
  logic          host_dir = 1'b0;
  logic [AW-1:0] host_addr = '0;
  logic          host_rdy;
  logic          per_sel_n;
  logic          per_ds_n;
  logic          per_rw;
  logic [AW-1:0] per_rs;
  logic          per_ack_n = 1'b1;

  int n_checks = 0;
  int n_fail = 0;

  strobe_bridge #(.ADDR_W(AW), .SYNC_STAGES(2)) u_dut (
    .clk(clk), .rst(rst), .host_sel_n(host_sel_n), .host_rd_n(host_rd_n),
    .host_wr_n(host_wr_n), .host_dir(host_dir), .host_addr(host_addr),
    .host_rdy(host_rdy), .per_sel_n(per_sel_n), .per_ds_n(per_ds_n),
    .per_rw(per_rw), .per_rs(per_rs), .per_ack_n(per_ack_n)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int exp_waits(input int lat);
    return lat + 2;
  endfunction

  function automatic logic exp_rw(input logic dir);
    return ~dir;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  endtask

  // One host cycle with a peripheral acknowledge after lat rising edges.
  task automatic xfer(input logic is_wr, input logic dir, input logic [AW-1:0] addr,
                      input int lat);
    int  waits;
    bit  ds_dropped;
    @(posedge clk); #1;
    host_sel_n = 1'b0;
    host_addr  = addr;
    host_dir   = dir;
    if (is_wr) host_wr_n = 1'b0; else host_rd_n = 1'b0;
    #1;
    check("R4", per_rw, exp_rw(dir));
    check("R5", {per_sel_n, per_rs}, {1'b0, addr});
    check("R6", host_rdy, 0);
    if (is_wr) begin
      check("R2", per_ds_n, 1);
      @(negedge clk); #1;
      check("R2", per_ds_n, 0);
    end else begin
      check("R1", per_ds_n, 0);
    end
    waits = 0;
    ds_dropped = 1'b0;
    fork
      begin
        repeat (lat) @(posedge clk);
        #1 per_ack_n = 1'b0;
      end
      begin
        do begin
          @(posedge clk); #2;
          waits++;
          if (!host_rdy && per_ds_n) ds_dropped = 1'b1;
        end while (!host_rdy && waits < 50);
      end
    join
    check("R6", waits, exp_waits(lat));
    check("R9", ds_dropped, 0);
    host_rd_n = 1'b1;
    host_wr_n = 1'b1;
    #1;
    check("R3", per_ds_n, 1);
    host_sel_n = 1'b1;
    per_ack_n  = 1'b1;
    #1;
    check("R7", host_rdy, 1);
    repeat (4) @(posedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    // Reset state: idle, then selected with acknowledge low during reset
    repeat (2) @(posedge clk); #2;
    check("R7", {host_rdy, per_ds_n}, 2'b11);
    host_sel_n = 1'b0;
    per_ack_n  = 1'b0;
    repeat (3) @(posedge clk); #2;
    check("R8", host_rdy, 0);
    per_ack_n = 1'b1;
    host_sel_n = 1'b1;
    @(posedge clk); #1;
    rst = 1'b0;
    repeat (3) @(posedge clk);

    // Directed corners
    xfer(1'b0, 1'b0, 4'h3, 0);
    xfer(1'b1, 1'b1, 4'hc, 0);
    xfer(1'b1, 1'b1, 4'h5, 6);
    xfer(1'b0, 1'b0, 4'hf, 9);

    // Strobes with chip select inactive
    @(posedge clk); #1;
    host_rd_n = 1'b0;
    #1;
    check("R7", {host_rdy, per_ds_n}, 2'b11);
    host_rd_n = 1'b1;
    host_wr_n = 1'b0;
    @(negedge clk); #1;
    check("R7", {host_rdy, per_ds_n}, 2'b11);
    host_wr_n = 1'b1;
    repeat (3) @(posedge clk);

    // Random cycles
    for (int i = 0; i < 40; i++) begin
      logic wr;
      wr = 1'($urandom_range(0, 1));
      xfer(wr, wr, 4'($urandom_range(0, 15)), int'($urandom_range(0, 7)));
    end

    summary();
  end

endmodule